// File: doc/BRIEF.md
# Hypervisor TLB Invalidate-All Engine

This block carries out an "invalidate everything for the hypervisor regime" command against a small tagged TLB. A command names the hypervisor regime (the plain EL2 regime, or the EL2&0 regime used when the host-extension mode is on), the EL2 security state, and whether the command is the XS-exclude (nXS) variant. Once the command is accepted, the engine walks the TLB one entry per cycle. It clears every valid stage 1 entry whose regime and security tags equal those of the command, whatever walk level the entry came from. Stage 2 entries and entries of other regimes or security states are kept.

On acceptance the engine also pulses a one-cycle broadcast toward the other processing elements in the outer shareable domain. It takes a snapshot of the outstanding-access tracker as well. Completion is signalled only after the sweep is over and the selected in-flight accesses have drained. The normal variant waits on every access in the snapshot. The nXS variant waits only on accesses whose XS attribute is 0. The 64-bit register operand that comes with the command carries no fields and has no effect on anything.

The TLB is modelled as a register array with a fill port and an index probe port, so that the surrounding logic can load and inspect it.

Top module: `hyp_tlb_flush`

## Requirements
- R1: Only stage 1 entries (stored stage tag 0) are cleared, at any level tag 0..3. Stage 2 entries (stage tag 1) stay valid even when their regime and security tags match.
- R2: An entry is cleared only if its regime tag equals the commanded regime and its security tag equals the commanded security state. Regime tag encoding: 0 EL1&0, 1 EL2, 2 EL2&0, 3 EL3. `cmdRegimeSel` 0 selects tag 1 and 1 selects tag 2. Security encoding: 0 secure, 1 non-secure, 2 realm, 3 root.
- R3: In the cycle after acceptance, `bcastValid` is high for exactly one cycle, with `bcastRegimeSel`, `bcastSecState` and `bcastExcludeXs` equal to the accepted command's fields.
- R4: In the normal variant (`cmdExcludeXs`=0), `done` does not assert while any access that was pending at acceptance is still pending, whatever its XS bit.
- R5: In the nXS variant (`cmdExcludeXs`=1), only accesses pending at acceptance with `accXs` bit 0 hold off `done`. Accesses with XS bit 1 do not delay it.
- R6: The value of `cmdOperand` has no effect on which entries are cleared, on the broadcast, or on completion timing.
- R7: An access that becomes pending after acceptance never delays `done`. This includes a tracker slot that was cleared and is then reused.
- R8: `busy` is high and `cmdReady` is low from the cycle after acceptance until `done`. Commands presented while busy are ignored. The sweep covers one entry per cycle, so with nothing pending `done` rises exactly ENTRIES+1 cycles after the acceptance edge.
- R9: `done` is a one-cycle pulse. It is raised only when the sweep has finished and the selected snapshot accesses have all cleared.
- R10: During the sweep, an entry that has not yet been reached still reads as valid. When `done` is high, no valid entry matching the command remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | High when a command can be accepted |
| cmdRegimeSel | input | 1 | 0 = EL2 regime, 1 = EL2&0 regime |
| cmdSecState | input | 2 | EL2 security state of the command |
| cmdExcludeXs | input | 1 | 1 = nXS variant |
| cmdOperand | input | 64 | Register operand, ignored |
| fillEn | input | 1 | Write one TLB entry (sets it valid) |
| fillIdx | input | IDXW | Entry index to write |
| fillStage2 | input | 1 | Stage tag of written entry (1 = stage 2) |
| fillRegime | input | 2 | Regime tag of written entry |
| fillSecState | input | 2 | Security tag of written entry |
| fillLevel | input | 2 | Walk level tag of written entry |
| fillXs | input | 1 | XS tag of written entry |
| probeIdx | input | IDXW | Entry index to read |
| probeValid | output | 1 | Valid bit of probed entry |
| probeStage2 | output | 1 | Stage tag of probed entry |
| probeRegime | output | 2 | Regime tag of probed entry |
| probeSecState | output | 2 | Security tag of probed entry |
| probeLevel | output | 2 | Level tag of probed entry |
| probeXs | output | 1 | XS tag of probed entry |
| accPending | input | NACC | Outstanding-access tracker, one bit per slot |
| accXs | input | NACC | XS attribute of each tracked access |
| bcastValid | output | 1 | One-cycle broadcast request to peers |
| bcastRegimeSel | output | 1 | Regime of broadcast |
| bcastSecState | output | 2 | Security state of broadcast |
| bcastExcludeXs | output | 1 | nXS flag of broadcast |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench loads entries that differ from the command in exactly one tag: stage, regime, security state or level. A design that matched too loosely would wipe stage 2 or foreign-regime entries, and one that matched too tightly would leave deep-level entries behind. Drain tests hold two tracked accesses with different XS bits and release them one by one. A design that ignored XS in the nXS variant, or applied it in the normal variant, would complete one cycle too late or too early. A slot that is released and then reused after acceptance checks that the snapshot really freezes. A design that watched the live tracker would hang there. Further checks probe an unreached entry in the middle of the sweep and present a rejected command while busy, which catch a sweep that clears everything at once and a design that accepts overlapping commands.

// File: rtl/hyp_tlb_flush_pkg.sv
package hyp_tlb_flush_pkg;

  // Regime tag carried by each TLB entry
  typedef enum logic [1:0] {
    RGM_EL10 = 2'd0,
    RGM_EL2  = 2'd1,
    RGM_EL20 = 2'd2,
    RGM_EL3  = 2'd3
  } regime_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_DRAIN = 2'd2
  } flushState_e;

  typedef struct packed {
    logic       valid;
    logic       stage2;
    regime_e    regime;
    logic [1:0] secState;
    logic [1:0] level;
    logic       xs;
  } tlbEntry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       start;      // latch key, reset sweep index, take snapshot
    logic       step;       // clear current index if it matches, advance
    logic       excludeXs;  // snapshot mask selection at start
    regime_e    regime;     // key regime at start
    logic [1:0] secState;   // key security state at start
  } sweepCtl_t;

endpackage

// File: rtl/hyp_tlb_flush_ctrl.sv
module hyp_tlb_flush_ctrl
  import hyp_tlb_flush_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic       cmdRegimeSel,
  input  logic [1:0] cmdSecState,
  input  logic       cmdExcludeXs,
  input  logic       sweepLast,
  input  logic       drained,
  output sweepCtl_t  ctl,
  output logic       bcastValid,
  output logic       bcastRegimeSel,
  output logic [1:0] bcastSecState,
  output logic       bcastExcludeXs,
  output logic       busy,
  output logic       done
);

  flushState_e stateQ, stateD;
  logic accept;
  logic doneD;

  assign accept   = cmdValid && (stateQ == ST_IDLE);
  assign cmdReady = (stateQ == ST_IDLE);
  assign busy     = (stateQ != ST_IDLE);

  always_comb begin
    ctl           = '0;
    ctl.start     = accept;
    ctl.step      = (stateQ == ST_SWEEP);
    ctl.excludeXs = cmdExcludeXs;
    ctl.regime    = cmdRegimeSel ? RGM_EL20 : RGM_EL2;
    ctl.secState  = cmdSecState;
  end

  always_comb begin
    stateD = stateQ;
    doneD  = 1'b0;
    unique case (stateQ)
      ST_IDLE:  if (accept) stateD = ST_SWEEP;
      ST_SWEEP: if (sweepLast) stateD = ST_DRAIN;
      ST_DRAIN: begin
        if (drained) begin
          stateD = ST_IDLE;
          doneD  = 1'b1;
        end
      end
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ         <= ST_IDLE;
      done           <= 1'b0;
      bcastValid     <= 1'b0;
      bcastRegimeSel <= 1'b0;
      bcastSecState  <= 2'd0;
      bcastExcludeXs <= 1'b0;
    end else begin
      stateQ     <= stateD;
      done       <= doneD;
      bcastValid <= accept;
      if (accept) begin
        bcastRegimeSel <= cmdRegimeSel;
        bcastSecState  <= cmdSecState;
        bcastExcludeXs <= cmdExcludeXs;
      end
    end
  end

endmodule

// File: rtl/hyp_tlb_flush_dp.sv
module hyp_tlb_flush_dp
  import hyp_tlb_flush_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NACC    = 4,
  localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  sweepCtl_t       ctl,
  input  logic            fillEn,
  input  logic [IDXW-1:0] fillIdx,
  input  logic            fillStage2,
  input  logic [1:0]      fillRegime,
  input  logic [1:0]      fillSecState,
  input  logic [1:0]      fillLevel,
  input  logic            fillXs,
  input  logic [IDXW-1:0] probeIdx,
  output tlbEntry_t       probeEntry,
  input  logic [NACC-1:0] accPending,
  input  logic [NACC-1:0] accXs,
  output logic            sweepLast,
  output logic            drained,
  output logic            matchLeft
);

  tlbEntry_t       tlbQ [ENTRIES];
  tlbEntry_t       fillEntry;
  logic [ENTRIES-1:0] hitVec;
  regime_e         keyRegimeQ;
  logic [1:0]      keySecQ;
  logic [IDXW-1:0] sweepIdxQ;
  logic [NACC-1:0] snapQ;

  always_comb begin
    fillEntry          = '0;
    fillEntry.valid    = 1'b1;
    fillEntry.stage2   = fillStage2;
    fillEntry.regime   = regime_e'(fillRegime);
    fillEntry.secState = fillSecState;
    fillEntry.level    = fillLevel;
    fillEntry.xs       = fillXs;
  end

  // Entry storage, one register slot per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign hitVec[g] = tlbQ[g].valid && !tlbQ[g].stage2 &&
                       (tlbQ[g].regime == keyRegimeQ) &&
                       (tlbQ[g].secState == keySecQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tlbQ[g] <= '0;
      end else if (ctl.step && (sweepIdxQ == IDXW'(g)) && hitVec[g]) begin
        tlbQ[g].valid <= 1'b0;
      end else if (fillEn && (fillIdx == IDXW'(g))) begin
        tlbQ[g] <= fillEntry;
      end
    end
  end

  assign matchLeft = |hitVec;

  always_comb begin
    if (int'(probeIdx) < ENTRIES) probeEntry = tlbQ[probeIdx];
    else                          probeEntry = '0;
  end

  // Match key and sweep index
  assign sweepLast = (sweepIdxQ == IDXW'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyRegimeQ <= RGM_EL2;
      keySecQ    <= 2'd0;
      sweepIdxQ  <= '0;
    end else if (ctl.start) begin
      keyRegimeQ <= ctl.regime;
      keySecQ    <= ctl.secState;
      sweepIdxQ  <= '0;
    end else if (ctl.step && !sweepLast) begin
      sweepIdxQ  <= sweepIdxQ + IDXW'(1);
    end
  end

  // Snapshot of accesses that completion must wait for; bits only fall
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapQ <= '0;
    end else if (ctl.start) begin
      snapQ <= accPending & (ctl.excludeXs ? ~accXs : {NACC{1'b1}});
    end else begin
      snapQ <= snapQ & accPending;
    end
  end

  assign drained = ~|(snapQ & accPending);

endmodule

// File: rtl/hyp_tlb_flush.sv
module hyp_tlb_flush
  import hyp_tlb_flush_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int NACC    = 4,
  localparam int IDXW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic            cmdRegimeSel,
  input  logic [1:0]      cmdSecState,
  input  logic            cmdExcludeXs,
  input  logic [63:0]     cmdOperand,
  input  logic            fillEn,
  input  logic [IDXW-1:0] fillIdx,
  input  logic            fillStage2,
  input  logic [1:0]      fillRegime,
  input  logic [1:0]      fillSecState,
  input  logic [1:0]      fillLevel,
  input  logic            fillXs,
  input  logic [IDXW-1:0] probeIdx,
  output logic            probeValid,
  output logic            probeStage2,
  output logic [1:0]      probeRegime,
  output logic [1:0]      probeSecState,
  output logic [1:0]      probeLevel,
  output logic            probeXs,
  input  logic [NACC-1:0] accPending,
  input  logic [NACC-1:0] accXs,
  output logic            bcastValid,
  output logic            bcastRegimeSel,
  output logic [1:0]      bcastSecState,
  output logic            bcastExcludeXs,
  output logic            busy,
  output logic            done
);

  sweepCtl_t ctl;
  tlbEntry_t probeEntry;
  logic      sweepLast;
  logic      drained;
  logic      matchLeft;
  logic      unusedOperand;

  // The operand carries no fields
  assign unusedOperand = ^cmdOperand;

  hyp_tlb_flush_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .cmdValid      (cmdValid),
    .cmdReady      (cmdReady),
    .cmdRegimeSel  (cmdRegimeSel),
    .cmdSecState   (cmdSecState),
    .cmdExcludeXs  (cmdExcludeXs),
    .sweepLast     (sweepLast),
    .drained       (drained),
    .ctl           (ctl),
    .bcastValid    (bcastValid),
    .bcastRegimeSel(bcastRegimeSel),
    .bcastSecState (bcastSecState),
    .bcastExcludeXs(bcastExcludeXs),
    .busy          (busy),
    .done          (done)
  );

  hyp_tlb_flush_dp #(
    .ENTRIES(ENTRIES),
    .NACC   (NACC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .fillEn      (fillEn),
    .fillIdx     (fillIdx),
    .fillStage2  (fillStage2),
    .fillRegime  (fillRegime),
    .fillSecState(fillSecState),
    .fillLevel   (fillLevel),
    .fillXs      (fillXs),
    .probeIdx    (probeIdx),
    .probeEntry  (probeEntry),
    .accPending  (accPending),
    .accXs       (accXs),
    .sweepLast   (sweepLast),
    .drained     (drained),
    .matchLeft   (matchLeft)
  );

  assign probeValid    = probeEntry.valid;
  assign probeStage2   = probeEntry.stage2;
  assign probeRegime   = probeEntry.regime;
  assign probeSecState = probeEntry.secState;
  assign probeLevel    = probeEntry.level;
  assign probeXs       = probeEntry.xs;

endmodule

// File: rtl/hyp_tlb_flush_chk.sv
module hyp_tlb_flush_chk #(
  parameter int ENTRIES = 8
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdReady,
  input logic busy,
  input logic done,
  input logic bcastValid,
  input logic matchLeft
);

  logic [15:0] busyCnt;
  logic        accepted;

  assign accepted = cmdValid && cmdReady;

  // Cycles since the last acceptance, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                     busyCnt <= '0;
    else if (accepted)             busyCnt <= '0;
    else if (busy && busyCnt != '1) busyCnt <= busyCnt + 16'd1;
  end

  p_bcast_after_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> bcastValid);

  p_bcast_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    bcastValid |=> !bcastValid);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> (busy && !cmdReady));

  p_done_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt >= 16'(ENTRIES + 1)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_clean_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !matchLeft);

endmodule

bind hyp_tlb_flush hyp_tlb_flush_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .busy      (busy),
  .done      (done),
  .bcastValid(bcastValid),
  .matchLeft (matchLeft)
);

// File: tb/hyp_tlb_flush_tb_top.sv
`timescale 1ns/1ps
module hyp_tlb_flush_tb_top;

  localparam int NENT = 8;
  localparam int NACC = 4;
  localparam int IW   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdReady, cmdRegimeSel = 1'b0, cmdExcludeXs = 1'b0;
  logic [1:0] cmdSecState = 2'd0;
  logic [63:0] cmdOperand = '0;
  logic fillEn = 1'b0, fillStage2 = 1'b0, fillXs = 1'b0;
  logic [IW-1:0] fillIdx = '0, probeIdx = '0;
  logic [1:0] fillRegime = '0, fillSecState = '0, fillLevel = '0;
  logic probeValid, probeStage2, probeXs;
  logic [1:0] probeRegime, probeSecState, probeLevel;
  logic [NACC-1:0] accPending = '0, accXs = '0;
  logic bcastValid, bcastRegimeSel, bcastExcludeXs, busy, done;
  logic [1:0] bcastSecState;

  int nChecks = 0;
  int nFails  = 0;

  // Bench model of the array
  bit       mValid [NENT];
  bit       mStage2[NENT];
  bit [1:0] mRegime[NENT];
  bit [1:0] mSec   [NENT];

  always #4 clk = ~clk;  // 125 MHz

  hyp_tlb_flush #(.ENTRIES(NENT), .NACC(NACC)) dut_i (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdRegimeSel(cmdRegimeSel),
    .cmdSecState(cmdSecState), .cmdExcludeXs(cmdExcludeXs), .cmdOperand(cmdOperand),
    .fillEn(fillEn), .fillIdx(fillIdx), .fillStage2(fillStage2), .fillRegime(fillRegime),
    .fillSecState(fillSecState), .fillLevel(fillLevel), .fillXs(fillXs),
    .probeIdx(probeIdx), .probeValid(probeValid), .probeStage2(probeStage2),
    .probeRegime(probeRegime), .probeSecState(probeSecState), .probeLevel(probeLevel),
    .probeXs(probeXs), .accPending(accPending), .accXs(accXs),
    .bcastValid(bcastValid), .bcastRegimeSel(bcastRegimeSel),
    .bcastSecState(bcastSecState), .bcastExcludeXs(bcastExcludeXs),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fillOne(input int idx, input bit st2, input bit [1:0] rg,
                         input bit [1:0] sec, input bit [1:0] lvl, input bit xs);
    @(negedge clk);
    fillEn = 1'b1; fillIdx = IW'(idx); fillStage2 = st2; fillRegime = rg;
    fillSecState = sec; fillLevel = lvl; fillXs = xs;
    @(negedge clk);
    fillEn = 1'b0;
    mValid[idx] = 1'b1; mStage2[idx] = st2; mRegime[idx] = rg; mSec[idx] = sec;
  endtask

  // Entries differing from an EL2/non-secure command in one tag each
  task automatic loadPattern();
    fillOne(0, 0, 2'd1, 2'd1, 2'd0, 0);
    fillOne(1, 1, 2'd1, 2'd1, 2'd2, 0);
    fillOne(2, 0, 2'd2, 2'd1, 2'd1, 0);
    fillOne(3, 0, 2'd1, 2'd0, 2'd2, 1);
    fillOne(4, 0, 2'd0, 2'd1, 2'd1, 0);
    fillOne(5, 0, 2'd1, 2'd1, 2'd3, 1);
    fillOne(6, 0, 2'd1, 2'd1, 2'd1, 0);
    fillOne(7, 0, 2'd2, 2'd0, 2'd2, 0);
  endtask

  function automatic void applyModel(input bit rsel, input bit [1:0] sec);
    bit [1:0] rg = rsel ? 2'd2 : 2'd1;
    for (int i = 0; i < NENT; i++)
      if (mValid[i] && !mStage2[i] && mRegime[i] == rg && mSec[i] == sec)
        mValid[i] = 1'b0;
  endfunction

  task automatic checkArray(input string req);
    for (int i = 0; i < NENT; i++) begin
      probeIdx = IW'(i);
      #1;
      check(probeValid == mValid[i], req, $sformatf("entry %0d valid", i),
            probeValid, mValid[i]);
    end
  endtask

  // Accept a command at the next edge; returns at the following negedge
  task automatic issue(input bit rsel, input bit [1:0] sec, input bit excl,
                       input logic [63:0] opnd);
    @(negedge clk);
    cmdValid = 1'b1; cmdRegimeSel = rsel; cmdSecState = sec;
    cmdExcludeXs = excl; cmdOperand = opnd;
    check(cmdReady == 1'b1, "R8", "ready before accept", cmdReady, 1);
    @(negedge clk);
    cmdValid = 1'b0;
    check(bcastValid == 1'b1, "R3", "bcast pulse", bcastValid, 1);
    check(bcastRegimeSel == rsel && bcastSecState == sec && bcastExcludeXs == excl,
          "R3", "bcast fields", {bcastRegimeSel, bcastSecState, bcastExcludeXs},
          {rsel, sec, excl});
    check(busy == 1'b1 && cmdReady == 1'b0, "R8", "busy after accept",
          {busy, cmdReady}, 2'b10);
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
    @(negedge clk);
    check(done == 1'b0, "R9", "done single pulse", done, 0);
  endtask

  task automatic resetAll();
    rstN = 1'b0;
    for (int i = 0; i < NENT; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    resetAll();
    check(cmdReady && !busy && !done && !bcastValid, "R8", "reset outputs",
          {cmdReady, busy, done, bcastValid}, 4'b1000);
    checkArray("R10");
  endtask

  task automatic testBasic(input logic [63:0] opnd);
    int cyc;
    resetAll();
    loadPattern();
    issue(1'b0, 2'd1, 1'b0, opnd);
    check(bcastValid == 1'b1, "R3", "bcast still high", 0, 0);
    waitDone(cyc);
    check(cyc == NENT + 1, "R8", "done latency", cyc, NENT + 1);
    applyModel(1'b0, 2'd1);
    checkArray("R1 R2 R6");
  endtask

  task automatic testEl20Secure();
    int cyc;
    resetAll();
    loadPattern();
    fillOne(5, 0, 2'd2, 2'd0, 2'd3, 0);
    fillOne(1, 1, 2'd2, 2'd0, 2'd1, 0);
    issue(1'b1, 2'd0, 1'b1, 64'hdead_beef_0123_4567);
    waitDone(cyc);
    check(cyc == NENT + 1, "R6", "latency with operand", cyc, NENT + 1);
    applyModel(1'b1, 2'd0);
    checkArray("R2");
  endtask

  task automatic testBusyIgnore();
    int cyc;
    bit sawBcast = 1'b0;
    resetAll();
    loadPattern();
    issue(1'b0, 2'd1, 1'b0, '0);
    @(negedge clk);
    cmdValid = 1'b1; cmdRegimeSel = 1'b1; cmdSecState = 2'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (bcastValid) sawBcast = 1'b1;
      check(cmdReady == 1'b0, "R8", "ready low while busy", cmdReady, 0);
    end
    cmdValid = 1'b0;
    waitDone(cyc);
    check(!sawBcast && !bcastValid && !busy, "R8", "second command ignored",
          {sawBcast, bcastValid, busy}, 0);
    applyModel(1'b0, 2'd1);
    checkArray("R8");
  endtask

  task automatic testMidSweep();
    int cyc;
    resetAll();
    loadPattern();
    issue(1'b0, 2'd1, 1'b0, '0);
    @(negedge clk);
    @(negedge clk);
    probeIdx = IW'(6);
    #1;
    check(probeValid == 1'b1, "R10", "unreached entry valid mid-sweep", probeValid, 1);
    probeIdx = IW'(0);
    #1;
    check(probeValid == 1'b0, "R10", "reached entry cleared", probeValid, 0);
    waitDone(cyc);
    probeIdx = IW'(6);
    #1;
    check(probeValid == 1'b0, "R10", "entry cleared after done", probeValid, 0);
  endtask

  task automatic testDrainNormal();
    bit early = 1'b0;
    resetAll();
    loadPattern();
    accPending = 4'b0011; accXs = 4'b0010;
    issue(1'b0, 2'd1, 1'b0, '0);
    for (int k = 0; k < NENT + 4; k++) begin
      @(negedge clk);
      if (done) early = 1'b1;
    end
    check(!early, "R4", "done held by pending", early, 0);
    accPending[0] = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R4", "XS=1 access still holds", done, 0);
    accPending[1] = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R4 R9", "done after full drain", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R9", "done pulse", done, 0);
  endtask

  task automatic testDrainNxs();
    bit early = 1'b0;
    resetAll();
    loadPattern();
    accPending = 4'b0011; accXs = 4'b0010;
    issue(1'b0, 2'd1, 1'b1, '0);
    for (int k = 0; k < NENT + 4; k++) begin
      @(negedge clk);
      if (done) early = 1'b1;
    end
    check(!early, "R5", "XS=0 access holds", early, 0);
    accPending[0] = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R5", "done with XS=1 pending", done, 1);
    accPending = '0; accXs = '0;
  endtask

  task automatic testLateAccess();
    int cyc;
    resetAll();
    loadPattern();
    accPending = 4'b0001; accXs = '0;
    issue(1'b0, 2'd1, 1'b0, '0);
    accPending[2] = 1'b1;
    @(negedge clk);
    accPending[0] = 1'b0;
    @(negedge clk);
    accPending[0] = 1'b1;
    cyc = 2;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
    check(cyc == NENT + 1, "R7", "late and reused accesses ignored", cyc, NENT + 1);
    accPending = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testBasic('0);
    testBasic('1);
    testEl20Secure();
    testBusyIgnore();
    testMidSweep();
    testDrainNormal();
    testDrainNxs();
    testLateAccess();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule